// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial-link PHY out of reset and then confirms that the PHY's receive PLL has settled. It never touches the PHY directly. Instead it drives a command port into a separate handshake master, which performs the actual register accesses on the PHY's indirect control bus. Each access is either an address capture, a data write that the PHY does not acknowledge, or a read. The master answers every acknowledged access with a response that either carries read data or flags a timeout.

A single start pulse launches the whole sequence. The sequencer first captures the PHY's clock/reset register address and writes the reset word to it. Because a PHY that is being reset cannot answer, the sequencer does not wait for a response to that write. It then runs a bounded poll loop. Each pass waits a programmable settle time, captures the lane status register address again, and reads that register. The loop ends when the lock bit shows up, when the attempt budget runs out, or at once if the master reports a timeout on any acknowledged access. The outcome is reported as a one-cycle done pulse that carries a two-bit result code.

Top module: `phy_pll_lock_seq`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o` and `cmd_valid_o` are all low.
- R2: A start seen while idle is accepted. In the next cycle the sequencer issues an address command (op 0) carrying `RST_REG_ADDR` (default 0x7F3F).
- R3: When that address response returns without timeout, the next cycle issues a write-without-acknowledge command (op 1) whose data has only bit `RESET_BIT` (bit 0) set. No response is awaited for it.
- R4: The settle wait lasts exactly `WAIT_CYCLES` cycles with no command. It runs after the reset write and after every unlocked read response. A status address command follows `WAIT_CYCLES + 1` cycles after the reset write command, and `WAIT_CYCLES + 1` cycles after an unlocked read response.
- R5: Every poll pass issues an address command (op 0) with `LANE_STAT_ADDR` (default 0x2003). The cycle after its response, it issues a read command (op 2, data 0). The status address is captured again before every read.
- R6: A read response without timeout whose bit `LOCK_BIT` (bit 1) is set ends the sequence. `done_o` is raised the next cycle with result 0 (locked), whatever the other data bits are.
- R7: At most `MAX_POLLS` (default 10) reads are issued. If none of them shows the lock bit, `done_o` follows the last read response by one cycle with result 1 (lock timeout). A lock on the final allowed read still gives result 0.
- R8: A response with the timeout flag set on any acknowledged access aborts the sequence. `done_o` is raised the next cycle with result 2 (access timeout), and no further command is issued.
- R9: A start seen while `busy_o` is high has no effect: the command stream and the result are unchanged.
- R10: A response that arrives while no acknowledged command is outstanding is ignored.
- R11: `done_o` is high for exactly one cycle, with `busy_o` still high. In the following cycle the block is idle and accepts a new start.
- R12: `cmd_valid_o` is never high in two consecutive cycles, and no command is issued while a response is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request, honoured only when idle |
| busy_o | output | 1 | Sequence in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Outcome: 0 locked, 1 lock timeout, 2 access timeout |
| cmd_valid_o | output | 1 | Command strobe to the handshake master |
| cmd_op_o | output | 2 | 0 address capture, 1 write without acknowledge, 2 read |
| cmd_data_o | output | 16 | Register address or write data; zero for reads |
| rsp_valid_i | input | 1 | Response strobe from the handshake master |
| rsp_timeout_i | input | 1 | Response reports an access timeout |
| rsp_rdata_i | input | 16 | Read data returned with a read response |

## Verification
The sequence is driven with the lock appearing on the first pass, on a middle pass with every other data bit set, on the final allowed pass, and never. Together these separate an early exit from a miscounted attempt budget, and a proper bit test from a test of the whole word. Timeouts are injected on the reset address, on a later status address and on a later read, so an abort at each access type is told apart from one that only works on the first access. Response latencies of one to three cycles and exact command cycle numbers expose any settle-length or ordering error. One run adds repeated starts and stray timeout responses outside any outstanding access, to show that both are ignored.

// File: rtl/phy_lock_seq_pkg.sv
package phy_lock_seq_pkg;

    localparam int unsigned PHY_WORD_W = 16;

    typedef enum logic [1:0] {
        OP_ADDR        = 2'd0,
        OP_WRITE_NOACK = 2'd1,
        OP_READ        = 2'd2
    } cmd_op_e;

    typedef enum logic [1:0] {
        RES_LOCKED         = 2'd0,
        RES_LOCK_TIMEOUT   = 2'd1,
        RES_ACCESS_TIMEOUT = 2'd2
    } seq_result_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_ADDR,
        ST_RST_ADDR_WT,
        ST_RST_WR,
        ST_SETTLE,
        ST_LANE_ADDR,
        ST_LANE_ADDR_WT,
        ST_LANE_RD,
        ST_LANE_RD_WT,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic                  valid;
        cmd_op_e               op;
        logic [PHY_WORD_W-1:0] data;
    } phy_cmd_t;

    typedef struct packed {
        logic                  valid;
        logic                  timeout;
        logic [PHY_WORD_W-1:0] rdata;
    } phy_rsp_t;

    typedef struct packed {
        logic ack_ok;
        logic ack_err;
        logic locked;
    } rsp_flags_t;

    function automatic logic [PHY_WORD_W-1:0] bit_mask(input int unsigned pos);
        logic [PHY_WORD_W-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/phy_lock_wait_timer.sv
module phy_lock_wait_timer
    import phy_lock_seq_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 7500
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned TW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
    localparam logic [TW-1:0] LOAD_VAL = TW'(WAIT_CYCLES - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/phy_lock_poll_counter.sv
module phy_lock_poll_counter
    import phy_lock_seq_pkg::*;
#(
    parameter int unsigned MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int unsigned PW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] LAST_VAL = PW'(MAX_POLLS - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == LAST_VAL);
endmodule

// File: rtl/phy_lock_rsp_decode.sv
module phy_lock_rsp_decode
    import phy_lock_seq_pkg::*;
#(
    parameter logic [PHY_WORD_W-1:0] LOCK_MASK = 16'h0002
) (
    input  phy_rsp_t   rsp_i,
    output rsp_flags_t flags_o
);
    always_comb begin
        flags_o.ack_ok  = rsp_i.valid && !rsp_i.timeout;
        flags_o.ack_err = rsp_i.valid &&  rsp_i.timeout;
        flags_o.locked  = |(rsp_i.rdata & LOCK_MASK);
    end
endmodule

// File: rtl/phy_lock_cmd_gen.sv
module phy_lock_cmd_gen
    import phy_lock_seq_pkg::*;
#(
    parameter logic [PHY_WORD_W-1:0] RST_REG_ADDR   = 16'h7F3F,
    parameter logic [PHY_WORD_W-1:0] LANE_STAT_ADDR = 16'h2003,
    parameter logic [PHY_WORD_W-1:0] RESET_WORD     = 16'h0001
) (
    input  seq_state_e st_i,
    output phy_cmd_t   cmd_o
);
    always_comb begin
        cmd_o = '{valid: 1'b0, op: OP_ADDR, data: '0};
        unique case (st_i)
            ST_RST_ADDR:  cmd_o = '{valid: 1'b1, op: OP_ADDR,        data: RST_REG_ADDR};
            ST_RST_WR:    cmd_o = '{valid: 1'b1, op: OP_WRITE_NOACK, data: RESET_WORD};
            ST_LANE_ADDR: cmd_o = '{valid: 1'b1, op: OP_ADDR,        data: LANE_STAT_ADDR};
            ST_LANE_RD:   cmd_o = '{valid: 1'b1, op: OP_READ,        data: '0};
            default:      cmd_o = '{valid: 1'b0, op: OP_ADDR,        data: '0};
        endcase
    end
endmodule

// File: rtl/phy_pll_lock_seq.sv
module phy_pll_lock_seq
    import phy_lock_seq_pkg::*;
#(
    parameter int unsigned           WAIT_CYCLES    = 7500,
    parameter int unsigned           MAX_POLLS      = 10,
    parameter logic [PHY_WORD_W-1:0] RST_REG_ADDR   = 16'h7F3F,
    parameter logic [PHY_WORD_W-1:0] LANE_STAT_ADDR = 16'h2003,
    parameter int unsigned           RESET_BIT      = 0,
    parameter int unsigned           LOCK_BIT       = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [1:0]            result_o,
    output logic                  cmd_valid_o,
    output logic [1:0]            cmd_op_o,
    output logic [PHY_WORD_W-1:0] cmd_data_o,
    input  logic                  rsp_valid_i,
    input  logic                  rsp_timeout_i,
    input  logic [PHY_WORD_W-1:0] rsp_rdata_i
);
    localparam logic [PHY_WORD_W-1:0] RESET_WORD = bit_mask(RESET_BIT);
    localparam logic [PHY_WORD_W-1:0] LOCK_MASK  = bit_mask(LOCK_BIT);

    seq_state_e  st_q, st_d;
    seq_result_e res_q, res_d;
    logic        fin_set;
    logic        poll_clr, poll_inc, poll_last;
    logic        tmr_load, tmr_expired;
    phy_rsp_t    rsp;
    rsp_flags_t  rflags;
    phy_cmd_t    cmd;

    assign rsp = '{valid: rsp_valid_i, timeout: rsp_timeout_i, rdata: rsp_rdata_i};

    phy_lock_rsp_decode #(
        .LOCK_MASK (LOCK_MASK)
    ) u_decode (
        .rsp_i   (rsp),
        .flags_o (rflags)
    );

    phy_lock_wait_timer #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    phy_lock_poll_counter #(
        .MAX_POLLS (MAX_POLLS)
    ) u_polls (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (poll_clr),
        .inc_i  (poll_inc),
        .last_o (poll_last)
    );

    phy_lock_cmd_gen #(
        .RST_REG_ADDR   (RST_REG_ADDR),
        .LANE_STAT_ADDR (LANE_STAT_ADDR),
        .RESET_WORD     (RESET_WORD)
    ) u_cmd (
        .st_i  (st_q),
        .cmd_o (cmd)
    );

    // Sequencing: only wait states look at responses, so strays are dropped.
    always_comb begin
        st_d     = st_q;
        res_d    = res_q;
        fin_set  = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d     = ST_RST_ADDR;
                    poll_clr = 1'b1;
                end
            end
            ST_RST_ADDR: st_d = ST_RST_ADDR_WT;
            ST_RST_ADDR_WT: begin
                if (rflags.ack_err) begin
                    st_d    = ST_FIN;
                    res_d   = RES_ACCESS_TIMEOUT;
                    fin_set = 1'b1;
                end else if (rflags.ack_ok) begin
                    st_d = ST_RST_WR;
                end
            end
            // The PHY cannot answer while it resets: go straight to settling.
            ST_RST_WR: st_d = ST_SETTLE;
            ST_SETTLE: begin
                if (tmr_expired) begin
                    st_d = ST_LANE_ADDR;
                end
            end
            ST_LANE_ADDR: st_d = ST_LANE_ADDR_WT;
            ST_LANE_ADDR_WT: begin
                if (rflags.ack_err) begin
                    st_d    = ST_FIN;
                    res_d   = RES_ACCESS_TIMEOUT;
                    fin_set = 1'b1;
                end else if (rflags.ack_ok) begin
                    st_d = ST_LANE_RD;
                end
            end
            ST_LANE_RD: st_d = ST_LANE_RD_WT;
            ST_LANE_RD_WT: begin
                if (rflags.ack_err) begin
                    st_d    = ST_FIN;
                    res_d   = RES_ACCESS_TIMEOUT;
                    fin_set = 1'b1;
                end else if (rflags.ack_ok) begin
                    if (rflags.locked) begin
                        st_d    = ST_FIN;
                        res_d   = RES_LOCKED;
                        fin_set = 1'b1;
                    end else if (poll_last) begin
                        st_d    = ST_FIN;
                        res_d   = RES_LOCK_TIMEOUT;
                        fin_set = 1'b1;
                    end else begin
                        st_d     = ST_SETTLE;
                        poll_inc = 1'b1;
                    end
                end
            end
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (st_d == ST_SETTLE) && (st_q != ST_SETTLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            res_q <= RES_LOCKED;
        end else begin
            st_q <= st_d;
            if (fin_set) begin
                res_q <= res_d;
            end
        end
    end

    assign busy_o      = (st_q != ST_IDLE);
    assign done_o      = (st_q == ST_FIN);
    assign result_o    = res_q;
    assign cmd_valid_o = cmd.valid;
    assign cmd_op_o    = cmd.op;
    assign cmd_data_o  = cmd.data;
endmodule

// File: rtl/phy_pll_lock_seq_chk.sv
module phy_pll_lock_seq_chk
    import phy_lock_seq_pkg::*;
#(
    parameter int unsigned           MAX_POLLS    = 10,
    parameter logic [PHY_WORD_W-1:0] RST_REG_ADDR = 16'h7F3F,
    parameter int unsigned           RESET_BIT    = 0,
    parameter int unsigned           LOCK_BIT     = 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic [1:0]            result_o,
    input logic                  cmd_valid_o,
    input logic [1:0]            cmd_op_o,
    input logic [PHY_WORD_W-1:0] cmd_data_o,
    input logic                  rsp_valid_i,
    input logic                  rsp_timeout_i,
    input logic [PHY_WORD_W-1:0] rsp_rdata_i
);
    localparam int unsigned CW = $clog2(MAX_POLLS + 2);
    localparam logic [PHY_WORD_W-1:0] LOCK_MASK  = bit_mask(LOCK_BIT);
    localparam logic [PHY_WORD_W-1:0] RESET_WORD = bit_mask(RESET_BIT);

    logic          awaiting_q;
    logic [CW-1:0] rd_cnt_q;
    logic          rsp_locked;

    assign rsp_locked = |(rsp_rdata_i & LOCK_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            awaiting_q <= 1'b0;
            rd_cnt_q   <= '0;
        end else begin
            if (cmd_valid_o && (cmd_op_o != OP_WRITE_NOACK)) begin
                awaiting_q <= 1'b1;
            end else if (rsp_valid_i) begin
                awaiting_q <= 1'b0;
            end
            if (!busy_o) begin
                rd_cnt_q <= '0;
            end else if (cmd_valid_o && (cmd_op_o == OP_READ)) begin
                rd_cnt_q <= rd_cnt_q + 1'b1;
            end
        end
    end

    a_r2_first_cmd: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (cmd_valid_o && cmd_op_o == OP_ADDR && cmd_data_o == RST_REG_ADDR));

    a_r3_reset_word: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_op_o == OP_WRITE_NOACK) |-> (cmd_data_o == RESET_WORD));

    a_r6_lock_source: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == RES_LOCKED) |-> $past(rsp_valid_i && !rsp_timeout_i && rsp_locked));

    a_r7_poll_bound: assert property (@(posedge clk) disable iff (rst)
        rd_cnt_q <= CW'(MAX_POLLS));

    a_r7_exhausted: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == RES_LOCK_TIMEOUT) |-> (rd_cnt_q == CW'(MAX_POLLS)));

    a_r8_abort: assert property (@(posedge clk) disable iff (rst)
        (awaiting_q && rsp_valid_i && rsp_timeout_i) |=> (done_o && result_o == RES_ACCESS_TIMEOUT));

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    a_r12_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);

    a_r12_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        awaiting_q |-> !cmd_valid_o);
endmodule

bind phy_pll_lock_seq phy_pll_lock_seq_chk #(
    .MAX_POLLS    (MAX_POLLS),
    .RST_REG_ADDR (RST_REG_ADDR),
    .RESET_BIT    (RESET_BIT),
    .LOCK_BIT     (LOCK_BIT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .result_o      (result_o),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_op_o      (cmd_op_o),
    .cmd_data_o    (cmd_data_o),
    .rsp_valid_i   (rsp_valid_i),
    .rsp_timeout_i (rsp_timeout_i),
    .rsp_rdata_i   (rsp_rdata_i)
);

// File: tb/phy_pll_lock_seq_tb_top.sv
module phy_pll_lock_seq_tb_top;
    import phy_lock_seq_pkg::*;

    localparam int WAITC = 12;
    localparam int MAXP  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_drv = 1'b0, start_noise = 1'b0;
    logic        start_i;
    logic        busy_o, done_o, cmd_valid_o;
    logic [1:0]  result_o, cmd_op_o;
    logic [15:0] cmd_data_o;
    logic        rsp_valid_i, rsp_timeout_i;
    logic [15:0] rsp_rdata_i;
    logic        model_v = 1'b0, model_to = 1'b0, stray_v = 1'b0;
    logic [15:0] model_d = '0;

    assign start_i       = start_drv | start_noise;
    assign rsp_valid_i   = model_v | stray_v;
    assign rsp_timeout_i = model_v ? model_to : stray_v;
    assign rsp_rdata_i   = model_v ? model_d : 16'h0002;

    always #10 clk = ~clk;

    phy_pll_lock_seq #(
        .WAIT_CYCLES (WAITC),
        .MAX_POLLS   (MAXP)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .result_o      (result_o),
        .cmd_valid_o   (cmd_valid_o),
        .cmd_op_o      (cmd_op_o),
        .cmd_data_o    (cmd_data_o),
        .rsp_valid_i   (rsp_valid_i),
        .rsp_timeout_i (rsp_timeout_i),
        .rsp_rdata_i   (rsp_rdata_i)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int op; int data; int at; } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_fail = 0;
    int    exp_done_at = -1, exp_res = 0, done_cnt = 0;
    string exp_done_tag = "R11";

    int          cfg_lat = 1, cfg_lock = 0, cfg_to = 0;
    logic [15:0] cfg_unl = 16'hFFFD, cfg_lk = 16'h0002;
    bit          cfg_noise = 0;
    int          cd = 0, acc_n = 0, poll_n = 0;
    logic        pend_to = 1'b0;
    logic [15:0] pend_d = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %s expected %s", tag, what, act, exp);
        end
    endtask

    function automatic void push(input int op, input int d, input int at, input string tag);
        exp_t e;
        e.op = op; e.data = d; e.at = at;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endfunction

    // Handshake-master model: answers acknowledged commands after cfg_lat cycles.
    always @(negedge clk) begin
        model_v     = 1'b0;
        stray_v     = 1'b0;
        start_noise = 1'b0;
        if (!busy_o) begin
            acc_n  = 0;
            poll_n = 0;
        end
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                model_v  = 1'b1;
                model_to = pend_to;
                model_d  = pend_d;
            end
        end
        if (cmd_valid_o && cmd_op_o != OP_WRITE_NOACK) begin
            acc_n++;
            if (cmd_op_o == OP_READ) poll_n++;
            pend_to = (acc_n == cfg_to);
            pend_d  = (cmd_op_o == OP_READ) ? ((poll_n == cfg_lock) ? cfg_lk : cfg_unl) : 16'h0000;
            cd      = cfg_lat;
        end
        // R10 stimulus: stray timeout responses when nothing is outstanding
        if (cfg_noise && cd == 0 && !model_v && (cyc % 3 == 0)) stray_v = 1'b1;
        // R9 stimulus: start pulses while busy
        if (cfg_noise && busy_o && (cyc % 4 == 1)) start_noise = 1'b1;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R12", "unexpected command",
                        $sformatf("op=%0d data=%h cyc=%0d", cmd_op_o, cmd_data_o, cyc), "none");
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cmd_op_o == e.op[1:0] && cmd_data_o == e.data[15:0] && cyc == e.at, t, "command",
                        $sformatf("op=%0d data=%h cyc=%0d", cmd_op_o, cmd_data_o, cyc),
                        $sformatf("op=%0d data=%h cyc=%0d", e.op, e.data[15:0], e.at));
                end
            end
            if (done_o) begin
                done_cnt++;
                chk(cyc == exp_done_at && result_o == exp_res[1:0], exp_done_tag, "done",
                    $sformatf("cyc=%0d res=%0d", cyc, result_o),
                    $sformatf("cyc=%0d res=%0d", exp_done_at, exp_res));
            end
        end
    end

    // Driver: computes the expected command stream and outcome, then starts.
    task automatic run(input int lat, input int lock_at, input int to_step,
                       input logic [15:0] unl, input logic [15:0] lk,
                       input bit noise, input string tag);
        int s, t, acc;
        bit fin;
        @(negedge clk);
        cfg_lat = lat; cfg_lock = lock_at; cfg_to = to_step;
        cfg_unl = unl; cfg_lk = lk; cfg_noise = noise;
        done_cnt = 0;
        s   = cyc;
        t   = s + 1;
        acc = 1;
        fin = 0;
        push(0, 16'h7F3F, t, "R2");
        if (to_step == 1) begin
            exp_done_at = t + lat + 1; exp_res = 2; exp_done_tag = "R8"; fin = 1;
        end else begin
            t += lat + 1;
            push(1, 16'h0001, t, "R3");
            t += WAITC + 1;
            for (int p = 1; p <= MAXP && !fin; p++) begin
                push(0, 16'h2003, t, (p == 1) ? "R4" : "R5");
                acc++;
                if (acc == to_step) begin
                    exp_done_at = t + lat + 1; exp_res = 2; exp_done_tag = "R8"; fin = 1;
                end else begin
                    t += lat + 1;
                    push(2, 0, t, "R5");
                    acc++;
                    if (acc == to_step) begin
                        exp_done_at = t + lat + 1; exp_res = 2; exp_done_tag = "R8"; fin = 1;
                    end else if (p == lock_at) begin
                        exp_done_at = t + lat + 1; exp_res = 0; exp_done_tag = "R6"; fin = 1;
                    end else if (p == MAXP) begin
                        exp_done_at = t + lat + 1; exp_res = 1; exp_done_tag = "R7"; fin = 1;
                    end else begin
                        t += lat + WAITC + 1;
                    end
                end
            end
        end
        if (noise) exp_done_tag = {exp_done_tag, "/R9/R10"};
        start_drv = 1'b1;
        @(negedge clk);
        start_drv = 1'b0;
        while (done_cnt == 0 && cyc < s + 3000) @(negedge clk);
        cfg_noise = 0;
        repeat (4) @(negedge clk);
        chk(done_cnt == 1, "R11", {tag, " done pulses"}, $sformatf("%0d", done_cnt), "1");
        chk(exp_q.size() == 0, tag, "commands left unissued", $sformatf("%0d", exp_q.size()), "0");
        chk(!busy_o, "R11", {tag, " idle after done"}, $sformatf("%0d", busy_o), "0");
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o, "R1", "busy after reset", $sformatf("%0d", busy_o), "0");
        chk(!done_o, "R1", "done after reset", $sformatf("%0d", done_o), "0");
        chk(!cmd_valid_o, "R1", "cmd_valid after reset", $sformatf("%0d", cmd_valid_o), "0");
        run(1, 1,  0, 16'hFFFD, 16'h0002, 0, "R6");  // lock on first pass
        run(3, 4,  0, 16'hFFFD, 16'hFFFE, 0, "R6");  // lock mid-way, other bits busy
        run(2, 0,  0, 16'hFFFD, 16'h0002, 0, "R7");  // never locks
        run(1, 10, 0, 16'hFFFD, 16'h0002, 0, "R7");  // lock on final allowed read
        run(1, 0,  1, 16'hFFFD, 16'h0002, 0, "R8");  // reset address times out
        run(2, 0,  4, 16'hFFFD, 16'h0002, 0, "R8");  // second status address times out
        run(1, 0,  7, 16'hFFFD, 16'h0002, 0, "R8");  // third read times out
        run(2, 3,  0, 16'hFFFD, 16'h0002, 1, "R9");  // starts while busy, stray responses (R10)
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 60000);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog: actual cycle %0d expected completion before 60000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule